// File: doc/BRIEF.md
# Banked video aperture address decoder

This block sits between a CPU port and the memories behind a 128 KiB legacy graphics window. Every byte access that enters the window is classified and sent to exactly one place. It can go to linear video memory through one of two 32 KiB banks, to the blitter's memory-mapped register file, or to the blitter's source-data sink. It can also be passed untouched to a legacy graphics path, or go nowhere. Reads that reach nothing return 0xFF.

Each bank has its own base and limit. The offset inside the bank is checked against the limit and added to the base. The sum is then scaled by a granularity control and masked to the size of video memory. A 256-byte sub-window steers accesses to blitter registers when an enable pattern is present. While a CPU-fed blit waits for source bytes, writes into the lower 64 KiB feed the blitter instead of memory, and a pulse marks each full line of source data.

Reads of two or four bytes are split into byte beats at consecutive addresses and assembled little-endian. The configuration is captured when the strobe is accepted and held for the whole access.

Top module: `vga_aperture_decoder`

## Requirements
- R1: When `ext_en_i` is 0 at acceptance, the access goes only to the legacy port. `legacy_addr_o` carries the full untruncated input address, and the write flag and write data are unchanged.
- R2: With the extension on, an address whose low 17 bits are below 0x10000 selects bank `addr[15]` with offset `addr[14:0]`. An offset inside the limit issues a video memory access at base+offset, masked to `VRAM_AW` bits.
- R3: An offset equal to or above the selected bank's limit issues no video memory access, and a read of it returns 0xFF.
- R4: If `gran_ctl_i` has both bits 4 and 2 set, base+offset is shifted left by 4. Otherwise, if bit 1 is set, it is shifted left by 3, and with neither it is not shifted. The mask is applied after the shift.
- R5: Low addresses 0x18000 to 0x180FF reach the blitter registers with offset `addr[7:0]`, but only while `(mmio_ctl_i & 0x44) == 0x04`. Otherwise they issue no request and read as 0xFF.
- R6: Any other window address reads as 0xFF and a write to it issues no request. No beat drives more than one of the four destinations.
- R7: While `blit_active_i` is 1, a write below 0x10000 becomes a blit push carrying the write data, whatever the bank limit. Reads in that range still go to video memory.
- R8: `blit_line_o` pulses together with every `BLIT_LINE_BYTES`-th push. The push count restarts whenever `blit_active_i` is 0.
- R9: `size_i` sets the read width: 0 gives one byte, 1 gives two, and 2 or 3 give four. Beat k uses address+k and is decoded on its own. Byte k lands in `rdata_o[8k+7:8k]`, the unread bytes are zero, and `busy_o` stays high until the last beat is issued.
- R10: After reset no request or `rvalid_o` is active. Requests for an accepted strobe appear in the next cycle. A byte read asserts `rvalid_o` one cycle after its strobe, and an N-byte read asserts it N cycles after.
- R11: Bank bases, limits, granularity, extension enable and register-window control are taken at acceptance. Later changes do not affect the beats of that access.
- R12: With the extension on, address bits above bit 16 play no part in decoding.
- R13: Writes are always a single byte whatever `size_i` says. A strobe raised while `busy_o` is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| size_i | input | 2 | Read width code |
| addr_i | input | IN_AW | Window-relative address |
| wdata_i | input | 8 | Write byte |
| ext_en_i | input | 1 | Extended decoding enable |
| mmio_ctl_i | input | 8 | Register-window control byte |
| gran_ctl_i | input | 8 | Granularity control byte |
| bank0_base_i | input | VRAM_AW | Bank 0 base |
| bank1_base_i | input | VRAM_AW | Bank 1 base |
| bank0_limit_i | input | LIM_W | Bank 0 limit |
| bank1_limit_i | input | LIM_W | Bank 1 limit |
| blit_active_i | input | 1 | CPU-fed blit awaiting source bytes |
| busy_o | output | 1 | Multi-byte read in progress |
| vram_req_o | output | 1 | Video memory request |
| vram_we_o | output | 1 | Video memory write |
| vram_addr_o | output | VRAM_AW | Video memory byte address |
| vram_wdata_o | output | 8 | Video memory write byte |
| vram_rdata_i | input | 8 | Video memory read byte, same cycle |
| mmio_req_o | output | 1 | Blitter register request |
| mmio_we_o | output | 1 | Blitter register write |
| mmio_off_o | output | 8 | Blitter register offset |
| mmio_wdata_o | output | 8 | Blitter register write byte |
| mmio_rdata_i | input | 8 | Blitter register read byte |
| blit_push_o | output | 1 | Source byte push |
| blit_data_o | output | 8 | Source byte |
| blit_line_o | output | 1 | Line of source bytes complete |
| legacy_req_o | output | 1 | Legacy path request |
| legacy_we_o | output | 1 | Legacy path write |
| legacy_addr_o | output | IN_AW | Legacy path address |
| legacy_wdata_o | output | 8 | Legacy path write byte |
| legacy_rdata_i | input | 8 | Legacy path read byte |
| rvalid_o | output | 1 | Read data valid |
| rdata_o | output | 32 | Assembled read data |

## Verification
The assertions watch properties that hold every cycle. At most one destination is driven per beat. A disabled extension always routes to the legacy port. A byte read returns one cycle after its strobe, and a write never starts a busy period. A blocked register-window access never raises a register request, a blit-time low write always becomes a push, and a line pulse never appears without a push. The arithmetic cannot be checked that way: the bank limit edge, both granularity shifts, the wrap of the address mask, the little-endian assembly across bank and region boundaries, and the configuration snapshot during a four-beat read are shown only by the bench's directed scenarios. Those scenarios compare the outputs against values worked out independently.

// File: rtl/vad_pkg.sv
package vad_pkg;
  typedef enum logic [2:0] {
    TGT_NONE   = 3'd0,
    TGT_VRAM   = 3'd1,
    TGT_MMIO   = 3'd2,
    TGT_BLIT   = 3'd3,
    TGT_LEGACY = 3'd4
  } tgt_e;

  localparam logic [7:0] EMPTY_BYTE = 8'hFF;

  // both 0x14 bits -> x16, else bit 1 -> x8
  function automatic logic [2:0] gran_shift(input logic [7:0] g);
    if ((g & 8'h14) == 8'h14) return 3'd4;
    else if (g[1])            return 3'd3;
    else                      return 3'd0;
  endfunction
endpackage

// File: rtl/vad_bank_xlate.sv
module vad_bank_xlate import vad_pkg::*; #(
  parameter int VRAM_AW = 22,
  parameter int LIM_W   = 16
) (
  input  logic               bank_i,
  input  logic [14:0]        off_i,
  input  logic [VRAM_AW-1:0] base0_i,
  input  logic [VRAM_AW-1:0] base1_i,
  input  logic [LIM_W-1:0]   lim0_i,
  input  logic [LIM_W-1:0]   lim1_i,
  input  logic [7:0]         gran_i,
  output logic               hit_o,
  output logic [VRAM_AW-1:0] addr_o
);
  localparam int SUM_W = VRAM_AW + 1;
  localparam int SCL_W = VRAM_AW + 5;

  logic [VRAM_AW-1:0] base;
  logic [LIM_W-1:0]   lim;
  logic [SUM_W-1:0]   sum;
  logic [SCL_W-1:0]   scaled;

  always_comb begin
    base   = bank_i ? base1_i : base0_i;
    lim    = bank_i ? lim1_i  : lim0_i;
    hit_o  = LIM_W'(off_i) < lim;
    sum    = SUM_W'(base) + SUM_W'(off_i);
    scaled = SCL_W'(sum) << gran_shift(gran_i);
    addr_o = scaled[VRAM_AW-1:0];
  end
endmodule

// File: rtl/vad_region_decode.sv
module vad_region_decode import vad_pkg::*; #(
  parameter int VRAM_AW = 22,
  parameter int LIM_W   = 16
) (
  input  logic [16:0]        a_i,
  input  logic               we_i,
  input  logic               ext_en_i,
  input  logic [7:0]         mmio_ctl_i,
  input  logic               blit_active_i,
  input  logic [VRAM_AW-1:0] base0_i,
  input  logic [VRAM_AW-1:0] base1_i,
  input  logic [LIM_W-1:0]   lim0_i,
  input  logic [LIM_W-1:0]   lim1_i,
  input  logic [7:0]         gran_i,
  output tgt_e               tgt_o,
  output logic [VRAM_AW-1:0] vaddr_o,
  output logic [7:0]         moff_o
);
  logic bank_hit;

  vad_bank_xlate #(.VRAM_AW(VRAM_AW), .LIM_W(LIM_W)) u_xlate (
    .bank_i (a_i[15]),
    .off_i  (a_i[14:0]),
    .base0_i(base0_i),
    .base1_i(base1_i),
    .lim0_i (lim0_i),
    .lim1_i (lim1_i),
    .gran_i (gran_i),
    .hit_o  (bank_hit),
    .addr_o (vaddr_o)
  );

  assign moff_o = a_i[7:0];

  always_comb begin
    tgt_o = TGT_NONE;
    if (!ext_en_i)                          tgt_o = TGT_LEGACY;
    else if (!a_i[16]) begin
      if (we_i && blit_active_i)            tgt_o = TGT_BLIT;
      else if (bank_hit)                    tgt_o = TGT_VRAM;
    end else if (a_i[16:8] == 9'h180) begin
      if ((mmio_ctl_i & 8'h44) == 8'h04)    tgt_o = TGT_MMIO;
    end
  end
endmodule

// File: rtl/vad_blit_sink.sv
module vad_blit_sink #(
  parameter int LINE_BYTES = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic push_i,
  output logic line_o
);
  localparam int CW = (LINE_BYTES > 1) ? $clog2(LINE_BYTES) : 1;
  localparam logic [CW-1:0] LAST = CW'(LINE_BYTES - 1);

  logic [CW-1:0] cnt_q;

  assign line_o = push_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (!active_i)  cnt_q <= '0;
    else if (push_i)     cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/vad_read_gather.sv
module vad_read_gather #(
  parameter int RD_BYTES = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  valid_i,
  input  logic [$clog2(RD_BYTES)-1:0] idx_i,
  input  logic                  last_i,
  input  logic [7:0]            byte_i,
  output logic                  rvalid_o,
  output logic [8*RD_BYTES-1:0] rdata_o
);
  localparam int DW = 8 * RD_BYTES;

  logic [DW-1:0] acc_q, merged;

  always_comb begin
    merged = (idx_i == '0) ? '0 : acc_q;
    merged[8*idx_i +: 8] = byte_i;
    rvalid_o = valid_i && last_i;
    rdata_o  = rvalid_o ? merged : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      acc_q <= '0;
    else if (valid_i) acc_q <= merged;
  end
endmodule

// File: rtl/vga_aperture_decoder.sv
module vga_aperture_decoder import vad_pkg::*; #(
  parameter int IN_AW           = 20,
  parameter int VRAM_AW         = 22,
  parameter int LIM_W           = 16,
  parameter int BLIT_LINE_BYTES = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [1:0]         size_i,
  input  logic [IN_AW-1:0]   addr_i,
  input  logic [7:0]         wdata_i,
  input  logic               ext_en_i,
  input  logic [7:0]         mmio_ctl_i,
  input  logic [7:0]         gran_ctl_i,
  input  logic [VRAM_AW-1:0] bank0_base_i,
  input  logic [VRAM_AW-1:0] bank1_base_i,
  input  logic [LIM_W-1:0]   bank0_limit_i,
  input  logic [LIM_W-1:0]   bank1_limit_i,
  input  logic               blit_active_i,
  output logic               busy_o,
  output logic               vram_req_o,
  output logic               vram_we_o,
  output logic [VRAM_AW-1:0] vram_addr_o,
  output logic [7:0]         vram_wdata_o,
  input  logic [7:0]         vram_rdata_i,
  output logic               mmio_req_o,
  output logic               mmio_we_o,
  output logic [7:0]         mmio_off_o,
  output logic [7:0]         mmio_wdata_o,
  input  logic [7:0]         mmio_rdata_i,
  output logic               blit_push_o,
  output logic [7:0]         blit_data_o,
  output logic               blit_line_o,
  output logic               legacy_req_o,
  output logic               legacy_we_o,
  output logic [IN_AW-1:0]   legacy_addr_o,
  output logic [7:0]         legacy_wdata_o,
  input  logic [7:0]         legacy_rdata_i,
  output logic               rvalid_o,
  output logic [31:0]        rdata_o
);
  localparam int RD_BYTES = 4;
  localparam int IW       = $clog2(RD_BYTES);

  // sequencer and configuration snapshot
  logic               busy_q;
  logic [IW-1:0]      idx_q, last_q;
  logic [IN_AW-1:0]   addr_q;
  logic [VRAM_AW-1:0] base0_q, base1_q;
  logic [LIM_W-1:0]   lim0_q, lim1_q;
  logic [7:0]         gran_q, mctl_q;
  logic               ext_q;

  logic               accept, issue, cur_we, cur_last;
  logic [IW-1:0]      cur_idx, req_last;
  logic [IN_AW-1:0]   cur_addr;
  logic [VRAM_AW-1:0] c_base0, c_base1;
  logic [LIM_W-1:0]   c_lim0, c_lim1;
  logic [7:0]         c_gran, c_mctl;
  logic               c_ext;

  tgt_e               dec_tgt;
  logic [VRAM_AW-1:0] dec_vaddr;
  logic [7:0]         dec_moff;

  always_comb begin
    accept = req_i && !busy_q;
    issue  = accept || busy_q;
    unique case (size_i)
      2'd0:    req_last = '0;
      2'd1:    req_last = IW'(1);
      default: req_last = IW'(RD_BYTES - 1);
    endcase
    if (we_i) req_last = '0;
    cur_idx  = busy_q ? idx_q : '0;
    cur_addr = (busy_q ? addr_q : addr_i) + IN_AW'(cur_idx);
    cur_last = busy_q ? (idx_q == last_q) : (req_last == '0);
    cur_we   = !busy_q && we_i;
    c_base0  = busy_q ? base0_q : bank0_base_i;
    c_base1  = busy_q ? base1_q : bank1_base_i;
    c_lim0   = busy_q ? lim0_q  : bank0_limit_i;
    c_lim1   = busy_q ? lim1_q  : bank1_limit_i;
    c_gran   = busy_q ? gran_q  : gran_ctl_i;
    c_mctl   = busy_q ? mctl_q  : mmio_ctl_i;
    c_ext    = busy_q ? ext_q   : ext_en_i;
  end

  vad_region_decode #(.VRAM_AW(VRAM_AW), .LIM_W(LIM_W)) u_decode (
    .a_i          (cur_addr[16:0]),
    .we_i         (cur_we),
    .ext_en_i     (c_ext),
    .mmio_ctl_i   (c_mctl),
    .blit_active_i(blit_active_i),
    .base0_i      (c_base0),
    .base1_i      (c_base1),
    .lim0_i       (c_lim0),
    .lim1_i       (c_lim1),
    .gran_i       (c_gran),
    .tgt_o        (dec_tgt),
    .vaddr_o      (dec_vaddr),
    .moff_o       (dec_moff)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      idx_q   <= '0;
      last_q  <= '0;
      addr_q  <= '0;
      base0_q <= '0;
      base1_q <= '0;
      lim0_q  <= '0;
      lim1_q  <= '0;
      gran_q  <= '0;
      mctl_q  <= '0;
      ext_q   <= 1'b0;
    end else if (accept) begin
      addr_q  <= addr_i;
      last_q  <= req_last;
      base0_q <= bank0_base_i;
      base1_q <= bank1_base_i;
      lim0_q  <= bank0_limit_i;
      lim1_q  <= bank1_limit_i;
      gran_q  <= gran_ctl_i;
      mctl_q  <= mmio_ctl_i;
      ext_q   <= ext_en_i;
      if (req_last != '0) begin
        busy_q <= 1'b1;
        idx_q  <= IW'(1);
      end
    end else if (busy_q) begin
      idx_q <= idx_q + 1'b1;
      if (idx_q == last_q) busy_q <= 1'b0;
    end
  end

  // beat stage: one registered beat per cycle
  logic               st_valid, st_we, st_last;
  tgt_e               st_tgt;
  logic [VRAM_AW-1:0] st_vaddr;
  logic [7:0]         st_moff, st_wdata;
  logic [IN_AW-1:0]   st_laddr;
  logic [IW-1:0]      st_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_valid <= 1'b0;
      st_we    <= 1'b0;
      st_last  <= 1'b0;
      st_tgt   <= TGT_NONE;
      st_vaddr <= '0;
      st_moff  <= '0;
      st_wdata <= '0;
      st_laddr <= '0;
      st_idx   <= '0;
    end else begin
      st_valid <= issue;
      st_we    <= issue && cur_we;
      st_last  <= cur_last;
      st_tgt   <= issue ? dec_tgt : TGT_NONE;
      st_vaddr <= dec_vaddr;
      st_moff  <= dec_moff;
      st_wdata <= wdata_i;
      st_laddr <= cur_addr;
      st_idx   <= cur_idx;
    end
  end

  assign busy_o         = busy_q;
  assign vram_req_o     = st_valid && (st_tgt == TGT_VRAM);
  assign vram_we_o      = vram_req_o && st_we;
  assign vram_addr_o    = st_vaddr;
  assign vram_wdata_o   = st_wdata;
  assign mmio_req_o     = st_valid && (st_tgt == TGT_MMIO);
  assign mmio_we_o      = mmio_req_o && st_we;
  assign mmio_off_o     = st_moff;
  assign mmio_wdata_o   = st_wdata;
  assign blit_push_o    = st_valid && (st_tgt == TGT_BLIT);
  assign blit_data_o    = st_wdata;
  assign legacy_req_o   = st_valid && (st_tgt == TGT_LEGACY);
  assign legacy_we_o    = legacy_req_o && st_we;
  assign legacy_addr_o  = st_laddr;
  assign legacy_wdata_o = st_wdata;

  vad_blit_sink #(.LINE_BYTES(BLIT_LINE_BYTES)) u_blit_sink (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .active_i(blit_active_i),
    .push_i  (blit_push_o),
    .line_o  (blit_line_o)
  );

  logic [7:0] beat_byte;
  always_comb begin
    unique case (st_tgt)
      TGT_VRAM:   beat_byte = vram_rdata_i;
      TGT_MMIO:   beat_byte = mmio_rdata_i;
      TGT_LEGACY: beat_byte = legacy_rdata_i;
      default:    beat_byte = EMPTY_BYTE;
    endcase
  end

  vad_read_gather #(.RD_BYTES(RD_BYTES)) u_gather (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (st_valid && !st_we),
    .idx_i   (st_idx),
    .last_i  (st_last),
    .byte_i  (beat_byte),
    .rvalid_o(rvalid_o),
    .rdata_o (rdata_o)
  );
endmodule

// File: rtl/vad_checker.sv
module vad_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_i,
  input logic       we_i,
  input logic [1:0] size_i,
  input logic [8:0] addr_hi_i,
  input logic       ext_en_i,
  input logic [7:0] mmio_ctl_i,
  input logic       blit_active_i,
  input logic       busy_o,
  input logic       vram_req_o,
  input logic       mmio_req_o,
  input logic       blit_push_o,
  input logic       blit_line_o,
  input logic       legacy_req_o,
  input logic       rvalid_o
);
  logic acc;
  assign acc = req_i && !busy_o;

  assert_legacy_only_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && !ext_en_i) |=> (legacy_req_o && !vram_req_o && !mmio_req_o && !blit_push_o));

  assert_mmio_blocked_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && ext_en_i && addr_hi_i == 9'h180 && ((mmio_ctl_i & 8'h44) != 8'h04)) |=> !mmio_req_o);

  assert_single_dest_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({vram_req_o, mmio_req_o, blit_push_o, legacy_req_o}));

  assert_blit_push_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && ext_en_i && we_i && !addr_hi_i[8] && blit_active_i) |=> blit_push_o);

  assert_line_with_push_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blit_line_o |-> blit_push_o);

  assert_no_data_while_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !rvalid_o);

  assert_byte_read_latency_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && !we_i && size_i == 2'd0) |=> rvalid_o);

  assert_write_single_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && we_i) |=> !busy_o);
endmodule

bind vga_aperture_decoder vad_checker u_vad_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_i        (req_i),
  .we_i         (we_i),
  .size_i       (size_i),
  .addr_hi_i    (addr_i[16:8]),
  .ext_en_i     (ext_en_i),
  .mmio_ctl_i   (mmio_ctl_i),
  .blit_active_i(blit_active_i),
  .busy_o       (busy_o),
  .vram_req_o   (vram_req_o),
  .mmio_req_o   (mmio_req_o),
  .blit_push_o  (blit_push_o),
  .blit_line_o  (blit_line_o),
  .legacy_req_o (legacy_req_o),
  .rvalid_o     (rvalid_o)
);

// File: tb/vga_aperture_decoder_bench.sv
`timescale 1ns/1ps
module vga_aperture_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [1:0]  size = 2'd0;
  logic [19:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        ext_en = 1'b0;
  logic [7:0]  mctl = '0, gran = '0;
  logic [21:0] base0 = '0, base1 = '0;
  logic [15:0] lim0 = 16'h8000, lim1 = 16'h8000;
  logic        blit_act = 1'b0;

  logic        busy, vreq, vwe, mreq, mwe, bpush, bline, lreq, lwe, rvalid;
  logic [21:0] vaddr;
  logic [7:0]  vwd, moff, mwd, bdata, lwd, vrd, mrd, lrd;
  logic [19:0] laddr;
  logic [31:0] rdata;

  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  assign vrd = vaddr[7:0] ^ 8'h5A;
  assign mrd = moff ^ 8'hC3;
  assign lrd = laddr[7:0] ^ 8'h3C;

  vga_aperture_decoder u_vga_aperture_decoder (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .size_i(size),
    .addr_i(addr), .wdata_i(wdata), .ext_en_i(ext_en), .mmio_ctl_i(mctl),
    .gran_ctl_i(gran), .bank0_base_i(base0), .bank1_base_i(base1),
    .bank0_limit_i(lim0), .bank1_limit_i(lim1), .blit_active_i(blit_act),
    .busy_o(busy), .vram_req_o(vreq), .vram_we_o(vwe), .vram_addr_o(vaddr),
    .vram_wdata_o(vwd), .vram_rdata_i(vrd), .mmio_req_o(mreq), .mmio_we_o(mwe),
    .mmio_off_o(moff), .mmio_wdata_o(mwd), .mmio_rdata_i(mrd),
    .blit_push_o(bpush), .blit_data_o(bdata), .blit_line_o(bline),
    .legacy_req_o(lreq), .legacy_we_o(lwe), .legacy_addr_o(laddr),
    .legacy_wdata_o(lwd), .legacy_rdata_i(lrd), .rvalid_o(rvalid), .rdata_o(rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // strobe one access; returns with the first beat visible
  task automatic strobe(input logic w, input logic [1:0] sz, input logic [19:0] a, input logic [7:0] d);
    @(negedge clk);
    req = 1'b1; we = w; size = sz; addr = a; wdata = d;
    @(posedge clk); #2;
    req = 1'b0;
  endtask

  task automatic step;
    @(posedge clk); #2;
  endtask

  function automatic logic [21:0] xl(input logic [21:0] b, input logic [14:0] o, input int sh);
    logic [31:0] s;
    s = (32'(b) + 32'(o)) << sh;
    return s[21:0];
  endfunction

  task automatic t_reset;
    chk("R10 reset rvalid", 32'(rvalid), 0);
    chk("R10 reset reqs", 32'({vreq, mreq, bpush, lreq}), 0);
    chk("R10 reset busy", 32'(busy), 0);
  endtask

  task automatic t_legacy;
    ext_en = 1'b0;
    strobe(1'b0, 2'd0, 20'h01234, 8'h00);
    chk("R1 legacy req", 32'({lreq, vreq, mreq, bpush}), 32'b1000);
    chk("R1 legacy addr", 32'(laddr), 32'h01234);
    chk("R1 legacy rdata", rdata, 32'(8'h34 ^ 8'h3C));
    strobe(1'b1, 2'd0, 20'hF8765, 8'h9E);
    chk("R1 legacy write addr", 32'(laddr), 32'hF8765);
    chk("R1 legacy write", 32'({lwe, lwd}), 32'h19E);
    ext_en = 1'b1;
  endtask

  task automatic t_bank;
    base0 = 22'h001000; base1 = 22'h020000; lim0 = 16'h8000; lim1 = 16'h8000; gran = 8'h00;
    strobe(1'b0, 2'd0, 20'h00100, 8'h00);
    chk("R2 bank0 addr", 32'({vreq, vaddr}), 32'({1'b1, 22'h001100}));
    chk("R10 byte read one cycle", 32'({rvalid, rdata}), 33'({1'b1, 32'(8'h00 ^ 8'h5A)}));
    strobe(1'b0, 2'd0, 20'h08010, 8'h00);
    chk("R2 bank1 addr", 32'(vaddr), 32'h020010);
    strobe(1'b0, 2'd0, 20'hE0100, 8'h00);
    chk("R12 upper bits ignored", 32'({vreq, lreq, vaddr}), 32'({2'b10, 22'h001100}));
    strobe(1'b1, 2'd0, 20'h00200, 8'hAB);
    chk("R2 bank write", 32'({vwe, vwd, vaddr}), 32'({1'b1, 8'hAB, 22'h001200}));
  endtask

  task automatic t_limit;
    lim0 = 16'h0100;
    strobe(1'b0, 2'd0, 20'h00100, 8'h00);
    chk("R3 at limit no req", 32'(vreq), 0);
    chk("R3 at limit reads FF", rdata, 32'hFF);
    strobe(1'b0, 2'd0, 20'h000FF, 8'h00);
    chk("R3 below limit", 32'({vreq, vaddr}), 32'({1'b1, 22'h0010FF}));
    lim0 = 16'h8000;
  endtask

  task automatic t_gran;
    base0 = 22'h000010;
    gran = 8'h14; strobe(1'b0, 2'd0, 20'h00003, 8'h00);
    chk("R4 x16", 32'(vaddr), 32'(xl(22'h10, 15'h3, 4)));
    gran = 8'h02; strobe(1'b0, 2'd0, 20'h00003, 8'h00);
    chk("R4 x8", 32'(vaddr), 32'(xl(22'h10, 15'h3, 3)));
    gran = 8'h16; strobe(1'b0, 2'd0, 20'h00003, 8'h00);
    chk("R4 x16 wins", 32'(vaddr), 32'(xl(22'h10, 15'h3, 4)));
    gran = 8'h10; strobe(1'b0, 2'd0, 20'h00003, 8'h00);
    chk("R4 partial bits no shift", 32'(vaddr), 32'h13);
    gran = 8'h00; base0 = 22'h3FFFF0; strobe(1'b0, 2'd0, 20'h00020, 8'h00);
    chk("R2 mask wrap", 32'(vaddr), 32'h000010);
    gran = 8'h14; base0 = 22'h3FFF00; strobe(1'b0, 2'd0, 20'h00000, 8'h00);
    chk("R4 mask after shift", 32'(vaddr), 32'h3FF000);
    gran = 8'h00; base0 = 22'h0;
  endtask

  task automatic t_mmio;
    mctl = 8'h04; strobe(1'b0, 2'd0, 20'h18025, 8'h00);
    chk("R5 mmio read", 32'({mreq, moff}), 32'h125);
    chk("R5 mmio rdata", rdata, 32'(8'h25 ^ 8'hC3));
    mctl = 8'h44; strobe(1'b0, 2'd0, 20'h18025, 8'h00);
    chk("R5 mmio blocked", 32'({mreq, rdata}), 33'h0_000000FF);
    mctl = 8'h00; strobe(1'b1, 2'd0, 20'h18025, 8'h11);
    chk("R5 mmio off no write", 32'({mreq, mwe, vreq}), 0);
    mctl = 8'h0C; strobe(1'b1, 2'd0, 20'h180FF, 8'h77);
    chk("R5 mmio write", 32'({mwe, moff, mwd}), 32'h1FF77);
  endtask

  task automatic t_other;
    strobe(1'b0, 2'd0, 20'h10000, 8'h00);
    chk("R6 hole read", 32'({vreq, mreq, bpush, lreq, rdata}), 36'h0_000000FF);
    strobe(1'b1, 2'd0, 20'h18100, 8'h55);
    chk("R6 past mmio window", 32'({vreq, mreq, bpush, lreq}), 0);
    strobe(1'b1, 2'd0, 20'h1C000, 8'h55);
    chk("R6 hole write", 32'({vreq, mreq, bpush, lreq}), 0);
  endtask

  task automatic t_blit;
    int lines = 0;
    blit_act = 1'b1; lim0 = 16'h0000;
    for (int i = 0; i < 5; i++) begin
      strobe(1'b1, 2'd0, 20'(i), 8'(8'hA0 + i));
      if (i == 0) chk("R7 push ignores limit", 32'({bpush, vreq, bdata}), 32'h2A0);
      lines += int'(bline);
    end
    @(negedge clk); blit_act = 1'b0;
    @(negedge clk); blit_act = 1'b1;
    for (int i = 0; i < 8; i++) begin
      strobe(1'b1, 2'd0, 20'h08000, 8'h00);
      if (i < 7) lines += int'(bline);
      else chk("R8 line on eighth push", 32'(bline), 1);
    end
    chk("R8 no early line after restart", 32'(lines), 0);
    lim0 = 16'h8000;
    strobe(1'b0, 2'd0, 20'h00040, 8'h00);
    chk("R7 read during blit", 32'({vreq, bpush, vaddr}), 32'({2'b10, 22'h000040}));
    blit_act = 1'b0;
  endtask

  task automatic t_wide;
    base0 = 22'h0; base1 = 22'h300000;
    strobe(1'b0, 2'd2, 20'h0FFFE, 8'h00);
    chk("R9 beat0", 32'({busy, rvalid, vaddr}), 32'({2'b10, 22'h307FFE}));
    step; chk("R9 beat1", 32'({busy, vaddr}), 32'({1'b1, 22'h307FFF}));
    step; chk("R9 beat2 hole", 32'({busy, vreq}), 32'b10);
    step; chk("R9 four byte rvalid", 32'({busy, rvalid}), 32'b01);
    chk("R9 little endian", rdata, 32'hFFFFA5A4);
    mctl = 8'h04;
    strobe(1'b0, 2'd1, 20'h18000, 8'h00);
    chk("R9 two byte busy", 32'({busy, rvalid}), 32'b10);
    step; chk("R9 two byte data", 32'({rvalid, rdata}), 33'h1_0000C2C3);
  endtask

  task automatic t_snapshot;
    int wr_seen = 0;
    base0 = 22'h000100; lim0 = 16'h8000; gran = 8'h00;
    strobe(1'b0, 2'd3, 20'h00010, 8'h00);
    base0 = 22'h200000; lim0 = 16'h0000; gran = 8'h14;
    chk("R11 beat0 addr", 32'(vaddr), 32'h110);
    req = 1'b1; we = 1'b1; addr = 20'h00500; size = 2'd0;
    step; chk("R11 beat1 addr", 32'({vreq, vaddr}), 32'({1'b1, 22'h111}));
    wr_seen += int'(vwe);
    step; chk("R11 beat2 addr", 32'({vreq, vaddr}), 32'({1'b1, 22'h112}));
    wr_seen += int'(vwe);
    req = 1'b0;
    step; chk("R11 snapshot data", rdata, 32'h49484B4A);
    wr_seen += int'(vwe) + int'(busy);
    chk("R13 strobe while busy ignored", 32'(wr_seen), 0);
    step; chk("R13 no late beat", 32'({vreq, rvalid}), 0);
    base0 = 22'h0; lim0 = 16'h8000; gran = 8'h00;
    strobe(1'b1, 2'd2, 20'h00300, 8'h5C);
    chk("R13 wide write single", 32'({busy, vwe, vaddr}), 32'({2'b01, 22'h300}));
    step; chk("R13 wide write one beat", 32'({busy, vreq}), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 t_reset();
    @(negedge clk); rst_n = 1'b1;
    t_legacy();
    t_bank();
    t_limit();
    t_gran();
    t_mmio();
    t_other();
    t_blit();
    t_wide();
    t_snapshot();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule